// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block produces the sixteen-times-baud clock enable pattern for a serial port. Software loads a 16-bit divisor through two byte-wide latches, one for the upper byte and one for the lower byte. A down-counter then splits the reference rate by that divisor and drives `baud_x16`.

The reference rate is either every cycle of `clk`, or one cycle in `PRESCALE_DIV` when the optional fixed pre-divider is on. The default pre-divider is 13, which turns a 24 MHz source into roughly 1.8462 MHz. Any write to either latch reloads the counter on the same edge, so a new divisor takes effect at once rather than after the old count has run out.

The control is a four-state machine:
- `BD_IDLE` is the state after reset. The output is held high and the counter does not run.
- `BD_FOLLOW` is entered for divisor 1.
- `BD_HALF` is entered for divisor 2.
- `BD_COUNT` is entered for divisor 0 and for divisors of 3 or more.

Every latch write is a `load` transition. It goes from any state to the state that the new divisor selects. There is no transition back to `BD_IDLE` except through reset. In `BD_HALF` and `BD_COUNT` the counter starts at the effective divisor. It steps down by one on each reference tick. When it reaches 1, the next tick reloads it.

Top module: `baud_div`

## Requirements
- R1: After reset, both latches read as zero, `div_value` is 0x0000 and `baud_x16` stays high until the first latch write.
- R2: `div_value` equals {upper latch, lower latch}. `wr_lo` changes only bits 7:0 (from `lo_wdata`) and `wr_hi` changes only bits 15:8 (from `hi_wdata`). With neither strobe high, `div_value` holds.
- R3: A write to either latch restarts the period on the edge that captures it. In the first cycle after that edge the counter holds the new effective divisor. For a divisor of 3 or more, the output is then high for the first divisor−2 reference cycles.
- R4: For a divisor D of 3 or more, `baud_x16` repeats with a period of D reference cycles. In each period it is high for D−2 cycles and then low for 2.
- R5: A divisor of 0 behaves as 3: the output is high for one reference cycle and low for two.
- R6: A divisor of 2 gives a 50% duty signal that alternates each reference cycle, starting high after the write.
- R7: A divisor of 1 makes `baud_x16` the complement of the reference tick. With the pre-divider off it is constantly low. With it on, it is low for one clock in every `PRESCALE_DIV`.
- R8: With `PRESCALE_ON`=1 the counter advances once every `PRESCALE_DIV` clocks, so with divisor 4 and the default of 13, any 104-cycle window in steady state holds exactly 52 low cycles. With `PRESCALE_ON`=0 it advances every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe for the lower divisor byte |
| lo_wdata | input | 8 | Data for the lower divisor byte |
| wr_hi | input | 1 | Write strobe for the upper divisor byte |
| hi_wdata | input | 8 | Data for the upper divisor byte |
| div_value | output | 16 | Divisor readback {upper, lower} |
| baud_x16 | output | 1 | Divided output at sixteen times the baud rate |

## Verification
Several properties are checked on every cycle:
- a write loads the counter with the effective divisor;
- the count stays between 1 and the divisor while in `BD_COUNT`;
- the output toggles on each tick in `BD_HALF`;
- the latches hold without a strobe;
- the idle state is only seen with a zero divisor;
- ticks from the pre-divider are never adjacent.

Only the bench scenarios can show the exact waveform. They cover the low/high split against an arithmetic model for every lower-byte divisor and a few multi-byte ones, the restart of the phase on a mid-period rewrite, and the low-cycle counts of the prescaled output.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    typedef enum logic [1:0] {
        BD_IDLE   = 2'd0,
        BD_FOLLOW = 2'd1,
        BD_HALF   = 2'd2,
        BD_COUNT  = 2'd3
    } bd_mode_e;

    // Divisor 0 is run as a divide-by-3.
    function automatic logic [15:0] eff_div(input logic [15:0] d);
        return (d == 16'd0) ? 16'd3 : d;
    endfunction

    function automatic bd_mode_e mode_of(input logic [15:0] d);
        if (d == 16'd1)      return BD_FOLLOW;
        else if (d == 16'd2) return BD_HALF;
        else                 return BD_COUNT;
    endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter bit PRE_EN  = 1'b1,
    parameter int PRE_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_tick
);
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (pre_q == LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign ref_tick = PRE_EN ? (pre_q == LAST) : 1'b1;

    generate
        if (PRE_EN && PRE_DIV > 1) begin : g_tick_chk
            // R8
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ref_tick |=> !ref_tick);
        end
    endgenerate

endmodule

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic [BW-1:0]   lo_wdata,
    input  logic            wr_hi,
    input  logic [BW-1:0]   hi_wdata,
    output logic [2*BW-1:0] div_q,
    output logic [2*BW-1:0] div_next,
    output logic            load
);
    assign load     = wr_lo | wr_hi;
    assign div_next = {wr_hi ? hi_wdata : div_q[2*BW-1:BW],
                       wr_lo ? lo_wdata : div_q[BW-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (load)
            div_q <= div_next;
    end

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable(div_q));

endmodule

// File: rtl/baud_div_fsm.sv
module baud_div_fsm
    import baud_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] div_next,
    input  logic [15:0] div_q,
    input  logic        ref_tick,
    output logic        baud_out
);
    bd_mode_e    state_q, state_n;
    logic [15:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (load) begin
            state_n = mode_of(div_next);
            cnt_n   = eff_div(div_next);
        end else if (ref_tick) begin
            unique case (state_q)
                BD_IDLE:   cnt_n = cnt_q;
                BD_FOLLOW: cnt_n = cnt_q;
                BD_HALF,
                BD_COUNT:  cnt_n = (cnt_q <= 16'd1) ? eff_div(div_q) : cnt_q - 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        unique case (state_q)
            BD_IDLE:   baud_out = 1'b1;
            BD_FOLLOW: baud_out = ~ref_tick;
            BD_HALF:   baud_out = (cnt_q == 16'd2);
            BD_COUNT:  baud_out = (cnt_q > 16'd2);
        endcase
    end

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == eff_div(div_q)));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BD_COUNT) |-> (cnt_q >= 16'd1 && cnt_q <= eff_div(div_q)));

    // R6
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BD_HALF && ref_tick && !load) |=> (baud_out != $past(baud_out)));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BD_IDLE) |-> (div_q == 16'd0));

endmodule

// File: rtl/baud_div.sv
module baud_div #(
    parameter bit PRESCALE_ON  = 1'b1,
    parameter int PRESCALE_DIV = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic [7:0]  lo_wdata,
    input  logic        wr_hi,
    input  logic [7:0]  hi_wdata,
    output logic [15:0] div_value,
    output logic        baud_x16
);
    logic        ref_tick;
    logic        load;
    logic [15:0] div_next;

    baud_prescale #(.PRE_EN(PRESCALE_ON), .PRE_DIV(PRESCALE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick)
    );

    baud_div_latch #(.BW(8)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo), .lo_wdata(lo_wdata),
        .wr_hi(wr_hi), .hi_wdata(hi_wdata),
        .div_q(div_value), .div_next(div_next), .load(load)
    );

    baud_div_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .load(load),
        .div_next(div_next), .div_q(div_value),
        .ref_tick(ref_tick), .baud_out(baud_x16)
    );

endmodule

// File: tb/test_baud_div.sv
module test_baud_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  lo_wdata = '0, hi_wdata = '0;
    logic [15:0] div_value, div_value_p;
    logic        baud_x16, baud_x16_p;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    baud_div #(.PRESCALE_ON(1'b0)) i_baud_div (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .lo_wdata(lo_wdata),
        .wr_hi(wr_hi), .hi_wdata(hi_wdata), .div_value(div_value), .baud_x16(baud_x16));

    baud_div #(.PRESCALE_ON(1'b1), .PRESCALE_DIV(13)) i_baud_div_pre (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .lo_wdata(lo_wdata),
        .wr_hi(wr_hi), .hi_wdata(hi_wdata), .div_value(div_value_p), .baud_x16(baud_x16_p));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_out(input int d, input int i);
        int e = (d == 0) ? 3 : d;
        if (d == 1) return 1'b0;
        if (d == 2) return (i % 2) == 0;
        return (i % e) < (e - 2);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write(input bit lo, input bit hi, input logic [15:0] d);
        step();
        wr_lo = lo; wr_hi = hi; lo_wdata = d[7:0]; hi_wdata = d[15:8];
        step();
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic run_check(input int d, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(baud_x16 == exp_out(d, i), req, baud_x16, exp_out(d, i));
            step();
        end
    endtask

    task automatic count_low_pre(input int skip, input int n, input int exp, input string req);
        int lows = 0;
        for (int i = 0; i < skip; i++) step();
        for (int i = 0; i < n; i++) begin
            if (!baud_x16_p) lows++;
            step();
        end
        chk(lows == exp, req, lows, exp);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        // R1: reset state holds until a write
        for (int i = 0; i < 20; i++) begin
            chk(baud_x16 == 1'b1 && baud_x16_p == 1'b1, "R1 out high", baud_x16, 1);
            chk(div_value == 16'd0, "R1 div zero", div_value, 0);
            step();
        end
        // R2: byte writes touch only their own byte
        write(1'b1, 1'b0, 16'h0005);
        chk(div_value == 16'h0005, "R2 lo write", div_value, 16'h0005);
        write(1'b0, 1'b1, 16'h0300);
        chk(div_value == 16'h0305, "R2 hi write", div_value, 16'h0305);
        write(1'b1, 1'b0, 16'h0001);
        chk(div_value == 16'h0301, "R2 lo keeps hi", div_value, 16'h0301);
        for (int i = 0; i < 5; i++) step();
        chk(div_value == 16'h0301, "R2 hold", div_value, 16'h0301);
        // R4 R5 R6 R7: sweep of every lower-byte divisor
        for (int d = 0; d < 256; d++) begin
            int e = (d == 0) ? 3 : d;
            write(1'b1, 1'b1, 16'(d));
            chk(div_value == 16'(d), "R2 sweep readback", div_value, d);
            run_check(d, 2 * e + 2,
                (d == 0) ? "R5" : (d == 1) ? "R7" : (d == 2) ? "R6" : "R4");
        end
        // R4: multi-byte divisors
        write(1'b1, 1'b1, 16'd256);  run_check(256, 520, "R4 256");
        write(1'b1, 1'b1, 16'd769);  run_check(769, 1540, "R4 769");
        // R3: rewrite mid-period restarts the phase
        write(1'b1, 1'b1, 16'd10);
        run_check(10, 4, "R3 before");
        write(1'b1, 1'b0, 16'd10);
        run_check(10, 20, "R3 restart");
        write(1'b0, 1'b1, 16'd10);
        run_check(10, 20, "R3 hi restart");
        // R8: prescaled output low counts
        write(1'b1, 1'b1, 16'd4);
        count_low_pre(60, 104, 52, "R8 div4 prescaled");
        // R7: divisor 1 with prescaler
        write(1'b1, 1'b1, 16'd1);
        count_low_pre(3, 26, 2, "R7 div1 prescaled");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule